// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block holds the slot control word and the command-completed status flag of a hot-plug capable downstream port. Software reaches both through a small register port that uses byte offsets. The block decides whether each write to the control word counts as a hot-plug command. Each command is handed to the slot hardware over a sideband valid/acknowledge handshake. The status flag is raised only when the hardware acknowledges the last outstanding command.

A mode input chooses how commands are recognised. In compliant mode, every write to the control word on a hot-plug capable port is a command, even when the value does not change. In legacy mode, a write is a command only when it alters one of the power controller, power indicator, attention indicator or interlock control fields. Writes that touch only other bits, such as notification enables, do not produce a command and leave the status flag unchanged. A strap input marks whether the port is hot-plug capable. On a port without that capability, writes never produce a command.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, the command-completed flag is 0 and `cmd_valid` is low.
- R2: A write to offset 0xA8 stores the 16-bit value, and a read of 0xA8 returns it one cycle after `rd_addr` is applied. Reads of offsets other than 0xA8 and 0xAA return 0.
- R3: In compliant mode (`legacy_mode`=0) with `hp_capable`=1, every write to 0xA8 is a command. This includes a rewrite of the same value. `cmd_valid` goes high on the cycle after the write, and `cmd_data` carries the written value.
- R4: In legacy mode (`legacy_mode`=1), a write to 0xA8 is a command only if it changes at least one of bits 11, 10, 9:8 or 7:6 (mask 0x0FC0) relative to the stored word. Other writes raise no command and leave the flag as it was.
- R5: With `hp_capable`=0, a write to 0xA8 still updates the word but never raises `cmd_valid` and never sets the flag.
- R6: `cmd_valid` stays high, with `cmd_data` stable, until a cycle in which `cmd_ack` is high. The flag is not set before that acknowledge. It is set on the acknowledging edge when no further command is waiting.
- R7: A read of 0xAA returns the flag at bit 4 and zeros elsewhere. Writing 0xAA with bit 4 set clears the flag. Writing 0xAA with bit 4 clear has no effect.
- R8: A command that arrives while another is being delivered is held. After the current acknowledge, only the newest held value is delivered. The flag is set only after that last delivery is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: only control-field changes are commands |
| hp_capable | input | 1 | Strap: port supports hot-plug commands |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Registered read data, one cycle latency |
| cmd_valid | output | 1 | Sideband command offered to slot hardware |
| cmd_data | output | 16 | Control word being delivered |
| cmd_ack | input | 1 | Slot hardware accepted the command |

## Verification
The bench sweeps all 64 values of the control fields in both modes. Each value is written three times: once as a fresh value, once unchanged, and once with only the unrelated bits flipped. A detector that ignored the mode, or compared the wrong bits, would raise or miss commands that the bench's mask arithmetic predicts. Delivery is checked before and after the acknowledge. A controller that set the flag at write time would show it early. A controller that dropped a command arriving mid-delivery, or delivered a stale one, would present the wrong word after the first acknowledge or set the flag too soon. Clear-on-one and the capability strap are probed with writes that must change nothing visible.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int          REG_W      = 16;
  localparam int          OFS_W      = 8;
  localparam logic [7:0]  CTRL_OFS   = 8'hA8;
  localparam logic [7:0]  STAT_OFS   = 8'hAA;
  localparam int          DONE_BIT   = 4;
  // power controller, power/attention indicators, interlock
  localparam logic [15:0] FIELD_MASK = 16'h0FC0;
endpackage

// File: rtl/hp_cmd_detect.sv
module hp_cmd_detect #(
  parameter int                 DW    = hp_slot_pkg::REG_W,
  parameter int                 AW    = hp_slot_pkg::OFS_W,
  parameter logic [AW-1:0]      CTRL  = hp_slot_pkg::CTRL_OFS,
  parameter logic [DW-1:0]      MASK  = hp_slot_pkg::FIELD_MASK
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] cur_word,
  input  logic          legacy_mode,
  input  logic          hp_capable,
  output logic          ctrl_wr,
  output logic          is_cmd
);
  logic field_change;

  always_comb begin
    ctrl_wr      = wr_en && (wr_addr == CTRL);
    field_change = |((wr_data ^ cur_word) & MASK);
    is_cmd       = ctrl_wr && hp_capable && (!legacy_mode || field_change);
  end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
  parameter int            DW   = hp_slot_pkg::REG_W,
  parameter int            AW   = hp_slot_pkg::OFS_W,
  parameter logic [AW-1:0] CTRL = hp_slot_pkg::CTRL_OFS,
  parameter logic [AW-1:0] STAT = hp_slot_pkg::STAT_OFS,
  parameter int            DBIT = hp_slot_pkg::DONE_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          set_done,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] cur_word,
  output logic          done_flag,
  output logic [DW-1:0] rd_data
);
  logic          clr_done;
  logic [DW-1:0] stat_view;

  always_comb begin
    clr_done  = wr_en && (wr_addr == STAT) && wr_data[DBIT];
    stat_view = '0;
    stat_view[DBIT] = done_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_word  <= '0;
      done_flag <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (ctrl_wr)
        cur_word <= wr_data;
      if (set_done)
        done_flag <= 1'b1;
      else if (clr_done)
        done_flag <= 1'b0;
      if (rd_addr == CTRL)
        rd_data <= cur_word;
      else if (rd_addr == STAT)
        rd_data <= stat_view;
      else
        rd_data <= '0;
    end
  end
endmodule

// File: rtl/hp_cmd_deliver.sv
module hp_cmd_deliver #(
  parameter int DW = hp_slot_pkg::REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          new_cmd,
  input  logic [DW-1:0] new_word,
  input  logic          cmd_ack,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  output logic          delivered
);
  logic          held;
  logic [DW-1:0] held_word;
  logic          accepted;

  always_comb begin
    accepted  = cmd_valid && cmd_ack;
    delivered = accepted && !held && !new_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      held      <= 1'b0;
      held_word <= '0;
    end else if (accepted) begin
      if (new_cmd) begin
        cmd_data <= new_word;
        held     <= 1'b0;
      end else if (held) begin
        cmd_data <= held_word;
        held     <= 1'b0;
      end else begin
        cmd_valid <= 1'b0;
      end
    end else if (new_cmd) begin
      if (cmd_valid) begin
        held      <= 1'b1;
        held_word <= new_word;
      end else begin
        cmd_valid <= 1'b1;
        cmd_data  <= new_word;
      end
    end
  end
endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl #(
  parameter int                 DW   = hp_slot_pkg::REG_W,
  parameter int                 AW   = hp_slot_pkg::OFS_W,
  parameter logic [AW-1:0]      CTRL = hp_slot_pkg::CTRL_OFS,
  parameter logic [AW-1:0]      STAT = hp_slot_pkg::STAT_OFS,
  parameter int                 DBIT = hp_slot_pkg::DONE_BIT,
  parameter logic [DW-1:0]      MASK = hp_slot_pkg::FIELD_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          legacy_mode,
  input  logic          hp_capable,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  input  logic          cmd_ack
);
  logic          ctrl_wr;
  logic          is_cmd;
  logic          delivered;
  logic          done_flag;
  logic [DW-1:0] cur_word;

  hp_cmd_detect #(.DW(DW), .AW(AW), .CTRL(CTRL), .MASK(MASK)) u_detect (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cur_word(cur_word),
    .legacy_mode(legacy_mode), .hp_capable(hp_capable),
    .ctrl_wr(ctrl_wr), .is_cmd(is_cmd)
  );

  hp_slot_regs #(.DW(DW), .AW(AW), .CTRL(CTRL), .STAT(STAT), .DBIT(DBIT)) u_regs (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .set_done(delivered), .rd_addr(rd_addr),
    .cur_word(cur_word), .done_flag(done_flag), .rd_data(rd_data)
  );

  hp_cmd_deliver #(.DW(DW)) u_deliver (
    .clk(clk), .rst(rst), .new_cmd(is_cmd), .new_word(wr_data), .cmd_ack(cmd_ack),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .delivered(delivered)
  );
endmodule

// File: rtl/hp_slot_cmd_chk.sv
module hp_slot_cmd_chk #(
  parameter int            DW   = 16,
  parameter int            AW   = 8,
  parameter logic [AW-1:0] CTRL = 8'hA8,
  parameter logic [AW-1:0] STAT = 8'hAA,
  parameter int            DBIT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          hp_capable,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cmd_valid,
  input logic [DW-1:0] cmd_data,
  input logic          cmd_ack,
  input logic          done_flag
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!cmd_valid && !done_flag));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_data)));

  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(cmd_valid && cmd_ack));

  // R5
  no_cmd_incapable_chk: assert property (@(posedge clk) disable iff (rst)
    (!hp_capable && !cmd_valid) |=> !cmd_valid);

  // R7
  clear_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done_flag) |-> $past(wr_en && (wr_addr == STAT) && wr_data[DBIT]));
endmodule

bind hp_slot_cmd_ctrl hp_slot_cmd_chk #(
  .DW(DW), .AW(AW), .CTRL(CTRL), .STAT(STAT), .DBIT(DBIT)
) u_chk (
  .clk(clk), .rst(rst), .hp_capable(hp_capable), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cmd_valid(cmd_valid),
  .cmd_data(cmd_data), .cmd_ack(cmd_ack), .done_flag(done_flag)
);

// File: tb/sim_hp_slot_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_cmd_ctrl;
  localparam logic [15:0] FMASK = 16'h0FC0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        legacy_mode = 1'b0;
  logic        hp_capable = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cmd_valid;
  logic [15:0] cmd_data;
  logic        cmd_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_word = '0;

  always #2.5 clk = ~clk;

  hp_slot_cmd_ctrl u0 (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .hp_capable(hp_capable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ack(cmd_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ack;
    @(negedge clk);
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
  endtask

  // one control write with full expectation, flag cleared first
  task automatic vec(input logic [15:0] v, input string req);
    logic        expect_cmd;
    logic [15:0] r;
    wr(8'hAA, 16'h0010);
    expect_cmd = hp_capable && (!legacy_mode || (((v ^ model_word) & FMASK) != 16'h0));
    wr(8'hA8, v);
    model_word = v;
    chk(cmd_valid == expect_cmd, req, {15'h0, cmd_valid}, {15'h0, expect_cmd});
    if (expect_cmd) begin
      chk(cmd_data == v, req, cmd_data, v);
      rd(8'hAA, r);
      chk(r == 16'h0000, "R6 early flag", r, 16'h0000);
      chk(cmd_valid && cmd_data == v, "R6 hold", cmd_data, v);
      ack();
      chk(!cmd_valid, "R6 drop", {15'h0, cmd_valid}, 16'h0);
      rd(8'hAA, r);
      chk(r == 16'h0010, "R6 flag set", r, 16'h0010);
    end else begin
      rd(8'hAA, r);
      chk(r == 16'h0000, req, r, 16'h0000);
    end
    rd(8'hA8, r);
    chk(r == v, "R2 readback", r, v);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!cmd_valid, "R1 valid", {15'h0, cmd_valid}, 16'h0);
    rd(8'hA8, r); chk(r == 16'h0, "R1 word", r, 16'h0);
    rd(8'hAA, r); chk(r == 16'h0, "R1 flag", r, 16'h0);
    rd(8'h10, r); chk(r == 16'h0, "R2 other offset", r, 16'h0);

    // R3 compliant and R4 legacy sweeps over every control-field value
    for (int m = 0; m < 2; m++) begin
      legacy_mode = m[0];
      for (int i = 0; i < 64; i++) begin
        logic [15:0] v;
        v = {i[3:0], i[5:0], 6'(i * 7)};
        vec(v, m ? "R4 new fields" : "R3 new fields");
        vec(v, m ? "R4 same value" : "R3 same value");
        vec(v ^ 16'hF03F, m ? "R4 other bits only" : "R3 other bits only");
      end
    end

    // R5 port without hot-plug capability
    hp_capable = 1'b0;
    for (int m = 0; m < 2; m++) begin
      legacy_mode = m[0];
      for (int i = 0; i < 8; i++) vec(16'(i * 16'h0240 + 16'h1), "R5 incapable");
    end
    hp_capable = 1'b1;

    // R8 overlapping commands, compliant mode
    legacy_mode = 1'b0;
    wr(8'hAA, 16'h0010);
    wr(8'hA8, 16'h0100);
    wr(8'hA8, 16'h0200);
    wr(8'hA8, 16'h0300);
    chk(cmd_valid && cmd_data == 16'h0100, "R8 first in flight", cmd_data, 16'h0100);
    ack();
    chk(cmd_valid && cmd_data == 16'h0300, "R8 newest held", cmd_data, 16'h0300);
    rd(8'hAA, r); chk(r == 16'h0, "R8 no early flag", r, 16'h0);
    ack();
    chk(!cmd_valid, "R8 idle after last", {15'h0, cmd_valid}, 16'h0);
    rd(8'hAA, r); chk(r == 16'h0010, "R8 flag after last", r, 16'h0010);

    // R7 clear-on-one behaviour
    wr(8'hAA, 16'h0000);
    rd(8'hAA, r); chk(r == 16'h0010, "R7 zero write ignored", r, 16'h0010);
    wr(8'hAA, 16'hFFEF);
    rd(8'hAA, r); chk(r == 16'h0010, "R7 other bits ignored", r, 16'h0010);
    wr(8'hAA, 16'h0010);
    rd(8'hAA, r); chk(r == 16'h0000, "R7 cleared", r, 16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule